// File: doc/BRIEF.md
# Counter-Mode Keystream Block Sequencer

This block generates the 128-bit input blocks that a block cipher running in counter mode encrypts to produce key stream. Software or a packet engine starts each packet with a one-cycle load pulse. The pulse fixes the upper part of the block, either from a 32-bit nonce and a 64-bit per-packet IV or from the upper bits of a full 128-bit value. The low counter field then starts at one. The sequencer offers one block at a time over a valid/ready handshake, and the cipher core consumes them.

Only the low `COUNTER_BITS` bits are ever incremented. A carry therefore cannot spill into the IV or nonce. When the block with an all-ones counter has been taken, the sequencer raises an exhausted flag and withholds further blocks until the next load. A running count of issued blocks is output so the consumer can see how close the packet is to the limit.

Top module: `ctr_block_gen`

## Requirements
- R1: After reset, out_valid and exhausted are low and block_index is zero. The block stays idle, whatever out_ready does, until the first load pulse.
- R2: With LOAD_WHOLE = 0, the cycle after a load gives out_valid high and an out_block built as follows:
  - load_nonce in bits [127:96] and load_iv in bits [95:32].
  - Bits [31:COUNTER_BITS] zero when the field is narrower than 32.
  - The counter field [COUNTER_BITS-1:0] equal to one. It is big-endian, so bits [7:0] (byte 15) hold its least significant byte.
- R3: The counter field increases by exactly one after each cycle in which out_valid and out_ready are both high, and only then.
- R4: While out_valid is high and out_ready is low, out_block and out_valid hold their values.
- R5: Bits [127:COUNTER_BITS] of out_block change only on a load. No increment ever carries into them.
- R6: Exhaustion works as follows:
  - Once the block whose counter field is all ones has been accepted, exhausted goes high and out_valid goes low on the next cycle.
  - Both stay that way until a load.
  - While out_valid is high, the counter field is never zero.
- R7: A load in the same cycle as a handshake wins. The next block carries the new prefix with counter one, and exhausted is cleared.
- R8: block_index equals the number of blocks accepted since the last load. It reads 2^COUNTER_BITS − 1 once exhausted.
- R9: With LOAD_WHOLE = 1, the fixed prefix is load_block[127:COUNTER_BITS], and load_nonce and load_iv have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start-of-packet pulse |
| load_nonce | input | 32 | Nonce for the layout mode |
| load_iv | input | 64 | Per-packet IV for the layout mode |
| load_block | input | 128 | Prefix source for the whole-block mode |
| out_ready | input | 1 | Consumer accepts the current block |
| out_valid | output | 1 | A counter block is offered |
| out_block | output | 128 | Current counter block |
| exhausted | output | 1 | Counter space used up |
| block_index | output | COUNTER_BITS | Blocks accepted since the last load |

## Verification
The bench drives a narrow 8-bit instance into its all-ones counter, so the boundary is reached in a few hundred cycles. A design that let the counter wrap would show a zero counter field or a changed prefix there. One that never stopped would keep valid high after the last block.

A load arriving together with a handshake, and a load issued while exhausted, expose a design that gives the handshake priority: it would emit counter two or stay exhausted. Long random stretches of stalls and reloads catch blocks that change during a stall and counters that skip or stick.

// File: rtl/ctr_block_gen.sv
module ctr_block_gen #(
  parameter int COUNTER_BITS = 32,
  parameter bit LOAD_WHOLE   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [31:0]             load_nonce,
  input  logic [63:0]             load_iv,
  input  logic [127:0]            load_block,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [127:0]            out_block,
  output logic                    exhausted,
  output logic [COUNTER_BITS-1:0] block_index
);
  localparam int PW = 128 - COUNTER_BITS;
  localparam logic [COUNTER_BITS-1:0] CNT_ONE  = COUNTER_BITS'(1);
  localparam logic [COUNTER_BITS-1:0] CNT_LAST = '1;

  logic [PW-1:0]           prefix_q, prefix_d;
  logic [COUNTER_BITS-1:0] cnt_q;
  logic                    exh_q, live_q;
  logic                    fire;

  generate
    if (LOAD_WHOLE) begin : g_whole
      assign prefix_d = load_block[127:COUNTER_BITS];
      wire unused_fields = ^{load_nonce, load_iv, load_block[COUNTER_BITS-1:0]};
    end else begin : g_layout
      wire [127:0] layout = {load_nonce, load_iv, 32'd0};
      assign prefix_d = layout[127:COUNTER_BITS];
      wire unused_fields = ^{load_block, layout[COUNTER_BITS-1:0]};
    end
  endgenerate

  assign out_valid   = live_q & ~exh_q;
  assign fire        = out_valid & out_ready;
  assign out_block   = {prefix_q, cnt_q};
  assign exhausted   = exh_q;
  assign block_index = exh_q ? CNT_LAST : cnt_q - CNT_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prefix_q <= '0;
      cnt_q    <= CNT_ONE;
      exh_q    <= 1'b0;
      live_q   <= 1'b0;
    end else if (load) begin
      prefix_q <= prefix_d;
      cnt_q    <= CNT_ONE;
      exh_q    <= 1'b0;
      live_q   <= 1'b1;
    end else if (fire) begin
      if (cnt_q == CNT_LAST) exh_q <= 1'b1;
      else                   cnt_q <= cnt_q + CNT_ONE;
    end
  end
endmodule

// File: rtl/ctr_block_gen_chk.sv
module ctr_block_gen_chk #(
  parameter int COUNTER_BITS = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load,
  input logic                    out_ready,
  input logic                    out_valid,
  input logic [127:0]            out_block,
  input logic                    exhausted,
  input logic [COUNTER_BITS-1:0] block_index
);
  localparam logic [COUNTER_BITS-1:0] ONE  = COUNTER_BITS'(1);
  localparam logic [COUNTER_BITS-1:0] LAST = '1;

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !load |=> out_valid && $stable(out_block));

  // R5
  prefix_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_block[127:COUNTER_BITS]));

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load && out_block[COUNTER_BITS-1:0] != LAST
    |=> out_block[COUNTER_BITS-1:0] == $past(out_block[COUNTER_BITS-1:0]) + ONE);

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_block[COUNTER_BITS-1:0] != '0);

  // R6
  exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load && out_block[COUNTER_BITS-1:0] == LAST
    |=> exhausted && !out_valid);

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && !exhausted && out_block[COUNTER_BITS-1:0] == ONE);

  // R8
  index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> block_index == out_block[COUNTER_BITS-1:0] - ONE);
endmodule

bind ctr_block_gen ctr_block_gen_chk #(.COUNTER_BITS(COUNTER_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .out_ready(out_ready),
  .out_valid(out_valid), .out_block(out_block), .exhausted(exhausted),
  .block_index(block_index)
);

// File: tb/test_ctr_block_gen.sv
module test_ctr_block_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_a = 1'b0, load_b = 1'b0, ready_a = 1'b0, ready_b = 1'b0;
  logic [31:0] nonce = '0;
  logic [63:0] iv = '0;
  logic [127:0] blk = '0;
  logic va, vb, ea, eb;
  logic [127:0] oa, ob;
  logic [31:0] ia;
  logic [7:0] ib;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [95:0] m_prefix;  logic [31:0] m_cnt;  logic m_exh, m_live;
  logic [119:0] g_prefix; logic [7:0] g_cnt;   logic g_exh, g_live;

  always #4 clk = ~clk;

  ctr_block_gen #(.COUNTER_BITS(32), .LOAD_WHOLE(1'b0)) i_ctr_block_gen (
    .clk(clk), .rst_n(rst_n), .load(load_a), .load_nonce(nonce), .load_iv(iv),
    .load_block(blk), .out_ready(ready_a), .out_valid(va), .out_block(oa),
    .exhausted(ea), .block_index(ia));

  ctr_block_gen #(.COUNTER_BITS(8), .LOAD_WHOLE(1'b1)) i_ctr_block_gen_w (
    .clk(clk), .rst_n(rst_n), .load(load_b), .load_nonce(nonce), .load_iv(iv),
    .load_block(blk), .out_ready(ready_b), .out_valid(vb), .out_block(ob),
    .exhausted(eb), .block_index(ib));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_a();
    return m_exh ? 32'hFFFF_FFFF : (m_live ? m_cnt - 32'd1 : 32'd0);
  endfunction
  function automatic logic [7:0] idx_b();
    return g_exh ? 8'hFF : (g_live ? g_cnt - 8'd1 : 8'd0);
  endfunction

  task automatic compare(input string tag);
    logic ev_a, ev_b;
    ev_a = m_live & ~m_exh;
    ev_b = g_live & ~g_exh;
    chk(va === ev_a, "R6 valid a", 128'(va), 128'(ev_a));
    chk(ea === m_exh, "R6 exhausted a", 128'(ea), 128'(m_exh));
    chk(ia === idx_a(), "R8 index a", 128'(ia), 128'(idx_a()));
    if (ev_a) chk(oa === {m_prefix, m_cnt}, tag, oa, {m_prefix, m_cnt});
    chk(vb === ev_b, "R6 valid b", 128'(vb), 128'(ev_b));
    chk(eb === g_exh, "R6 exhausted b", 128'(eb), 128'(g_exh));
    chk(ib === idx_b(), "R8 index b", 128'(ib), 128'(idx_b()));
    if (ev_b) chk(ob === {g_prefix, g_cnt}, tag, ob, {g_prefix, g_cnt});
  endtask

  task automatic cycle(input logic la, input logic ra, input logic lb, input logic rb, input string tag);
    logic ev_a, ev_b;
    load_a = la; ready_a = ra; load_b = lb; ready_b = rb;
    ev_a = m_live & ~m_exh;
    ev_b = g_live & ~g_exh;
    if (la) begin
      m_prefix = {nonce, iv}; m_cnt = 32'd1; m_exh = 1'b0; m_live = 1'b1;
    end else if (ev_a && ra) begin
      if (m_cnt == 32'hFFFF_FFFF) m_exh = 1'b1; else m_cnt = m_cnt + 32'd1;
    end
    if (lb) begin
      g_prefix = blk[127:8]; g_cnt = 8'd1; g_exh = 1'b0; g_live = 1'b1;
    end else if (ev_b && rb) begin
      if (g_cnt == 8'hFF) g_exh = 1'b1; else g_cnt = g_cnt + 8'd1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20050708));
    m_prefix = '0; m_cnt = 32'd1; m_exh = 0; m_live = 0;
    g_prefix = '0; g_cnt = 8'd1; g_exh = 0; g_live = 0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(va === 1'b0 && ea === 1'b0 && ia === '0, "R1 reset a", {va, ea, ia}, '0);
    chk(vb === 1'b0 && eb === 1'b0 && ib === '0, "R1 reset b", {vb, eb, ib}, '0);
    rst_n = 1'b1;
    // R1: ready alone does not start anything
    repeat (3) cycle(0, 1, 0, 1, "R1");

    // R2: layout mode load
    nonce = 32'hA1B2C3D4; iv = 64'h0011223344556677;
    blk = 128'hFEDCBA98_76543210_0F1E2D3C_4B5A6978;
    cycle(1, 0, 1, 0, "R2");
    chk(oa[127:96] === 32'hA1B2C3D4 && oa[95:32] === iv, "R2 fields", oa, {nonce, iv, 32'd1});
    chk(oa[7:0] === 8'h01 && oa[31:8] === '0, "R2 byte15", 128'(oa[31:0]), 128'd1);
    // R9: whole-block prefix, nonce and iv ignored
    chk(ob[127:8] === blk[127:8] && ob[7:0] === 8'h01, "R9 prefix", ob, {blk[127:8], 8'h01});
    nonce = 32'h0; iv = 64'h0;
    // R4: stall
    repeat (3) cycle(0, 0, 0, 0, "R4");
    // R3: advance
    repeat (5) cycle(0, 1, 0, 1, "R3");
    // R7: load with handshake
    nonce = 32'h55AA55AA; iv = 64'hDEADBEEF_CAFEF00D;
    cycle(1, 1, 0, 0, "R7");

    // R6: drive narrow instance to exhaustion
    blk = 128'h0123456789ABCDEF_FFFFFFFF_FFFFFFFF;
    cycle(0, 0, 1, 1, "R9");
    for (int k = 0; k < 300; k++) cycle(0, 0, 0, 1, "R6");
    chk(eb === 1'b1 && vb === 1'b0 && ib === 8'hFF, "R6 exhausted state", {eb, vb, ib}, {1'b1, 1'b0, 8'hFF});
    chk(ob[127:8] === blk[127:8], "R5 prefix untouched", ob, {blk[127:8], 8'hFF});
    // R7: load while exhausted, with ready high
    blk = 128'h11112222333344445555666677778888;
    cycle(0, 0, 1, 1, "R7");
    chk(eb === 1'b0 && vb === 1'b1 && ob[7:0] === 8'h01, "R7 clear", {eb, vb, ob[7:0]}, {1'b0, 1'b1, 8'h01});

    // R5: random traffic with stalls and reloads
    for (int k = 0; k < 4000; k++) begin
      logic la, lb;
      nonce = $urandom; iv = {$urandom, $urandom};
      blk = {$urandom, $urandom, $urandom, $urandom};
      la = ($urandom % 32) == 0;
      lb = ($urandom % 64) == 0;
      cycle(la, 1'($urandom), lb, ($urandom % 4) != 0, "R5");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule